// File: doc/BRIEF.md
# NAND Page Hamming Parity Accumulator

This block watches the data bus of an external memory controller. It builds a row-and-column Hamming parity code over every byte sent to one chosen NAND chip select. Software programs three write-only registers. The configuration register names the chip select to watch, gives the device width and enables the block. The size register gives the length of the ECC block in 16-bit words. The control register clears the sums and arms the block.

Each accepted transfer carries one byte on an 8-bit device or two bytes on a 16-bit device. The block folds that data into twelve pairs of even and odd parities: three column pairs and nine row pairs. When the programmed number of bytes has been taken, it freezes the packed 32-bit code and raises a done flag. The code is not inverted, so software compares it directly against the code stored in the spare area.

Top module: `nand_ecc_hamming`

## Requirements
- R1: After reset `ecc_result` is zero and `ecc_done` is low.
- R2: A register write to address 0 with bit 8 set clears the sums, the byte count and `ecc_done` at that clock edge. Bit 8 is not stored, so a later write to address 0 with bit 8 low leaves the sums untouched.
- R3: Bits [3:0] of the address-0 write pick the result slot. Value 1 arms accumulation. Any other value, 0 included, stops it.
- R4: Address 1 holds the enable in bit 0 and the watched chip select in bits [3:1]. A transfer counts only when the enable is 1 and `bus_cs` equals the watched chip select.
- R5: Bit 7 of address 1 set to 1 selects a 16-bit device. Each transfer then adds two bytes: `bus_data[7:0]` at the even byte index and `bus_data[15:8]` at the next index. With bit 7 set to 0, each transfer adds only `bus_data[7:0]`.
- R6: Bits [29:22] of address 2 hold N, the block size in 16-bit words minus one. `ecc_done` rises at the edge that takes in byte 2*(N+1), and the result already includes that byte. A 512-byte block is programmed as 255.
- R7: Column parities over bit positions of byte b, accumulated by XOR over all accepted bytes:
  - Result bit 0 is P1e, the XOR of b0, b2, b4 and b6. Bit 16 is P1o, the XOR of b1, b3, b5 and b7.
  - Bit 1 is P2e, the XOR of b0, b1, b4 and b5. Bit 17 is P2o, the XOR of b2, b3, b6 and b7.
  - Bit 2 is P4e, the XOR of b0 to b3. Bit 18 is P4o, the XOR of b4 to b7.
- R8: Row parities follow the 9-bit byte index i and the byte parity p, the XOR of all eight bits of b. For each k from 0 to 8:
  - When i[k] is 1, p is folded into result bit 19+k (odd parity P(8<<k)o).
  - When i[k] is 0, p is folded into result bit 3+k (even parity P(8<<k)e).
  - This places P8 to P128 in bits [7:3] and [23:19], and P256 to P2048 in bits [11:8] and [27:24].
  - Bits [15:12] and [31:28] are always zero.
- R9: The code is not inverted. A full block of 0xFF bytes yields an all-zero result.
- R10: While `ecc_done` is high, transfers have no effect. The result and `ecc_done` hold until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 configuration, 2 size |
| reg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A data transfer is on the bus this cycle |
| bus_cs | input | 3 | Chip select of the transfer |
| bus_data | input | 16 | Transfer data; lower byte only on an 8-bit device |
| ecc_result | output | 32 | Packed even and odd parities |
| ecc_done | output | 1 | Block complete, result frozen |

## Verification
A wrong byte count shows at the ports in two ways: `ecc_done` rises at the wrong transfer, or bytes are folded under the wrong index. A wrong index flips row bits in the result one cycle after the transfer concerned. A bad lane split in 16-bit mode, or a column-mask error, flips a low result bit on the first transfer whose data exercises it. The result is compared after every transfer and register write, so any fault appears within one cycle of its cause. A missing freeze or a leaking gate shows up as a change on the transfer that should have been ignored.

// File: rtl/ecc_pkg.sv
// Shared constants for the NAND Hamming parity accumulator.
// Assumes byte-wide lanes and a 32-bit result split in two 16-bit halves.
package ecc_pkg;
    localparam int BYTE_W       = 8;
    localparam int COL_N        = 3;
    localparam int RES_W        = 32;
    localparam int HALF_W       = 16;
    localparam int CLR_BIT      = 8;
    localparam int SEL_W        = 4;
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_CS_LSB   = 1;
    localparam int CFG_WIDE_BIT = 7;
    localparam int SIZE_LSB     = 22;
    localparam logic [SEL_W-1:0] SEL_RES1 = 4'd1;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_SIZE = 2'd2
    } reg_addr_e;
endpackage

// File: rtl/ecc_regs.sv
// Write-only register file: control slot select, configuration, block size.
// The clear command is decoded straight from the write and never stored.
module ecc_regs
    import ecc_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int CS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic              clr,
    output logic [SEL_W-1:0]  sel,
    output logic              en,
    output logic [CS_W-1:0]   cs,
    output logic              wide,
    output logic [SIZE_W-1:0] words_m1
);
    logic unused_wbits;

    // Pulse that clears the accumulator on a control write with the clear bit.
    always_comb clr = wr && (reg_addr_e'(addr) == ADDR_CTRL) && wdata[CLR_BIT];

    assign unused_wbits = ^{wdata[31:SIZE_LSB+SIZE_W], wdata[SIZE_LSB-1:CLR_BIT+1],
                            wdata[CFG_WIDE_BIT-1:CFG_CS_LSB+CS_W]};

    // Register updates on software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel      <= '0;
            en       <= 1'b0;
            cs       <= '0;
            wide     <= 1'b0;
            words_m1 <= '0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                ADDR_CTRL: sel <= wdata[SEL_W-1:0];
                ADDR_CFG: begin
                    en   <= wdata[CFG_EN_BIT];
                    cs   <= wdata[CFG_CS_LSB +: CS_W];
                    wide <= wdata[CFG_WIDE_BIT];
                end
                ADDR_SIZE: words_m1 <= wdata[SIZE_LSB +: SIZE_W];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ecc_lane.sv
// Parity contribution of one byte lane: three column pairs from bit positions,
// ROW_N row pairs from the byte index gating the byte's overall parity.
// Outputs are zero when the lane is not in use.
module ecc_lane
    import ecc_pkg::*;
#(
    parameter int ROW_N = 9,
    localparam int PAR_N = COL_N + ROW_N
) (
    input  logic              lane_en,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ROW_N-1:0]  idx,
    output logic [PAR_N-1:0]  ev,
    output logic [PAR_N-1:0]  od
);
    logic par;

    // Overall byte parity feeding every row pair.
    always_comb par = lane_en & (^byte_in);

    // Column pairs from alternating bit positions.
    always_comb begin
        ev[0] = lane_en & (byte_in[0] ^ byte_in[2] ^ byte_in[4] ^ byte_in[6]);
        od[0] = lane_en & (byte_in[1] ^ byte_in[3] ^ byte_in[5] ^ byte_in[7]);
        ev[1] = lane_en & (byte_in[0] ^ byte_in[1] ^ byte_in[4] ^ byte_in[5]);
        od[1] = lane_en & (byte_in[2] ^ byte_in[3] ^ byte_in[6] ^ byte_in[7]);
        ev[2] = lane_en & (^byte_in[3:0]);
        od[2] = lane_en & (^byte_in[7:4]);
    end

    // One row pair per index bit.
    for (genvar r = 0; r < ROW_N; r++) begin : g_row
        assign ev[COL_N+r] = par & ~idx[r];
        assign od[COL_N+r] = par &  idx[r];
    end
endmodule

// File: rtl/ecc_accum.sv
// Byte counter, parity sums and result packing. Folds all active lanes of a
// taken transfer in one cycle, stops at the programmed byte count.
// Assumes SIZE_W <= 12 so each parity set fits a 16-bit half.
module ecc_accum
    import ecc_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int DATA_W = 16,
    localparam int ROW_N = SIZE_W + 1,
    localparam int PAR_N = COL_N + ROW_N,
    localparam int CNT_W = SIZE_W + 2,
    localparam int LANES = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic              wide,
    input  logic [SIZE_W-1:0] words_m1,
    input  logic [DATA_W-1:0] bus_data,
    output logic [RES_W-1:0]  result,
    output logic              done
);
    logic [CNT_W-1:0] cnt, cnt_nx, target;
    logic [PAR_N-1:0] acc_ev, acc_od, sum_ev, sum_od;
    logic [PAR_N-1:0] lane_ev [LANES];
    logic [PAR_N-1:0] lane_od [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ROW_N-1:0] idx_l;
        assign idx_l = cnt[ROW_N-1:0] + ROW_N'(l);
        ecc_lane #(.ROW_N(ROW_N)) lane_i (
            .lane_en ((l == 0) || wide),
            .byte_in (bus_data[l*BYTE_W +: BYTE_W]),
            .idx     (idx_l),
            .ev      (lane_ev[l]),
            .od      (lane_od[l])
        );
    end

    // Combine all lane contributions of the current transfer.
    always_comb begin
        sum_ev = '0;
        sum_od = '0;
        for (int l = 0; l < LANES; l++) begin
            sum_ev = sum_ev ^ lane_ev[l];
            sum_od = sum_od ^ lane_od[l];
        end
    end

    // Next byte count and the byte total of one block.
    always_comb begin
        cnt_nx = cnt + (wide ? CNT_W'(LANES) : CNT_W'(1));
        target = (CNT_W'(words_m1) + CNT_W'(1)) << 1;
    end

    // Accumulate until the block is complete, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_ev <= '0;
            acc_od <= '0;
            cnt    <= '0;
            done   <= 1'b0;
        end else if (take && !done) begin
            acc_ev <= acc_ev ^ sum_ev;
            acc_od <= acc_od ^ sum_od;
            cnt    <= cnt_nx;
            done   <= (cnt_nx >= target);
        end
    end

    // Even set in the low half, odd set in the high half.
    always_comb begin
        result = '0;
        result[PAR_N-1:0]       = acc_ev;
        result[HALF_W +: PAR_N] = acc_od;
    end
endmodule

// File: rtl/nand_ecc_hamming.sv
// Top of the NAND Hamming parity accumulator: registers plus accumulator.
// A transfer is taken when enabled, slot 1 is armed and the chip select matches.
module nand_ecc_hamming
    import ecc_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int DATA_W = 16,
    parameter int CS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              bus_valid,
    input  logic [CS_W-1:0]   bus_cs,
    input  logic [DATA_W-1:0] bus_data,
    output logic [RES_W-1:0]  ecc_result,
    output logic              ecc_done
);
    logic              clr, cfg_en, cfg_wide, take;
    logic [SEL_W-1:0]  ctl_sel;
    logic [CS_W-1:0]   cfg_cs;
    logic [SIZE_W-1:0] words_m1;

    ecc_regs #(.SIZE_W(SIZE_W), .CS_W(CS_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .clr      (clr),
        .sel      (ctl_sel),
        .en       (cfg_en),
        .cs       (cfg_cs),
        .wide     (cfg_wide),
        .words_m1 (words_m1)
    );

    // Snoop qualifier for the watched chip select.
    always_comb take = bus_valid && cfg_en && (ctl_sel == SEL_RES1) && (bus_cs == cfg_cs);

    ecc_accum #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .take     (take),
        .wide     (cfg_wide),
        .words_m1 (words_m1),
        .bus_data (bus_data),
        .result   (ecc_result),
        .done     (ecc_done)
    );
endmodule

// File: rtl/nand_ecc_hamming_chk.sv
// Property checker for nand_ecc_hamming, attached by bind below.
module nand_ecc_hamming_chk #(
    parameter int CS_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr_req,
    input logic            bus_valid,
    input logic [CS_W-1:0] bus_cs,
    input logic [3:0]      sel,
    input logic [CS_W-1:0] cfg_cs,
    input logic [31:0]     ecc_result,
    input logic            ecc_done
);
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (ecc_result == 32'd0) && !ecc_done);

    p_slot_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sel != 4'd1 && !clr_req) |=> $stable(ecc_result) && $stable(ecc_done));

    p_cs_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bus_cs != cfg_cs && !clr_req) |=> $stable(ecc_result) && $stable(ecc_done));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !bus_valid && !clr_req) |=> $stable(ecc_result) && $stable(ecc_done));

    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ecc_done) |-> $past(bus_valid));

    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_done && !clr_req) |=> ecc_done && $stable(ecc_result));
endmodule

bind nand_ecc_hamming nand_ecc_hamming_chk #(.CS_W(CS_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_req    (reg_wr && reg_addr == 2'd0 && reg_wdata[8]),
    .bus_valid  (bus_valid),
    .bus_cs     (bus_cs),
    .sel        (ctl_sel),
    .cfg_cs     (cfg_cs),
    .ecc_result (ecc_result),
    .ecc_done   (ecc_done)
);

// File: tb/nand_ecc_hamming_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks update a reference model and queue the
// expected port values; a monitor pops and compares one cycle later.
module nand_ecc_hamming_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        bus_valid;
    logic [2:0]  bus_cs;
    logic [15:0] bus_data;
    logic [31:0] ecc_result;
    logic        ecc_done;

    always #5 clk = ~clk;

    nand_ecc_hamming dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .bus_valid(bus_valid), .bus_cs(bus_cs),
        .bus_data(bus_data), .ecc_result(ecc_result), .ecc_done(ecc_done)
    );

    typedef struct {
        logic [31:0] res;
        logic        done;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;

    logic [11:0] m_ev = '0, m_od = '0;
    int          m_cnt = 0;
    int          m_words_m1 = 0;
    bit          m_done = 0, m_en = 0, m_wide = 0;
    logic [2:0]  m_cs = '0;
    logic [3:0]  m_sel = '0;

    function automatic logic [31:0] m_pack();
        return {4'b0, m_od, 4'b0, m_ev};
    endfunction

    // Model of one byte folded at index idx (R7, R8).
    function automatic void m_byte(logic [7:0] b, int idx);
        logic p;
        m_ev[0] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
        m_od[0] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
        m_ev[1] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
        m_od[1] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
        m_ev[2] ^= ^b[3:0];
        m_od[2] ^= ^b[7:4];
        p = ^b;
        for (int k = 0; k < 9; k++) begin
            if (((idx >> k) & 1) == 1) m_od[3+k] ^= p;
            else                       m_ev[3+k] ^= p;
        end
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.res = m_pack();
        e.done = m_done;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            2'd0: begin
                m_sel = d[3:0];
                if (d[8]) begin m_ev = '0; m_od = '0; m_cnt = 0; m_done = 0; end
            end
            2'd1: begin m_en = d[0]; m_cs = d[3:1]; m_wide = d[7]; end
            2'd2: m_words_m1 = int'(d[29:22]);
            default: ;
        endcase
        push(tag);
    endtask

    task automatic xfer(logic [2:0] cs, logic [15:0] d, string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_cs = cs; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0;
        if (m_en && m_sel == 4'd1 && cs == m_cs && !m_done) begin
            if (m_wide) begin
                m_byte(d[7:0], m_cnt);
                m_byte(d[15:8], m_cnt + 1);
                m_cnt += 2;
            end else begin
                m_byte(d[7:0], m_cnt);
                m_cnt += 1;
            end
            if (m_cnt >= 2 * (m_words_m1 + 1)) m_done = 1;
        end
        push(tag);
    endtask

    // Monitor: compare every queued expectation just after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (ecc_result !== e.res || ecc_done !== e.done) begin
                    n_fail++;
                    $display("FAIL %s: result=%h done=%0b expected result=%h done=%0b",
                             e.tag, ecc_result, ecc_done, e.res, e.done);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        bus_valid = 1'b0; bus_cs = '0; bus_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push("R1 reset state");

        // 8-bit device on chip select 2, block of 2 words (4 bytes).
        reg_write(2'd1, 32'h0000_0005, "R4 config cs2 8-bit");
        reg_write(2'd2, 32'd1 << 22, "R6 size N=1");
        reg_write(2'd0, 32'h0000_0101, "R2 clear and arm slot 1");
        xfer(3'd3, 16'h00A7, "R4 other chip select ignored");
        xfer(3'd2, 16'h0001, "R7 column bit0 at index 0");
        xfer(3'd2, 16'h0002, "R8 row index 1");
        reg_write(2'd0, 32'h0000_0000, "R3 slot 0 disables");
        xfer(3'd2, 16'h0055, "R3 transfer ignored with slot 0");
        reg_write(2'd0, 32'h0000_0001, "R2 rearm without clear keeps sums");
        reg_write(2'd1, 32'h0000_0004, "R4 enable off");
        xfer(3'd2, 16'h0011, "R4 transfer ignored while disabled");
        reg_write(2'd1, 32'h0000_0005, "R4 enable on");
        xfer(3'd2, 16'h00C3, "R7 byte index 2");
        xfer(3'd2, 16'hFF80, "R6 done after 4 bytes, R5 upper byte unused");
        xfer(3'd2, 16'h00FF, "R10 frozen after done");
        reg_write(2'd0, 32'h0000_0001, "R10 done held without clear");

        // 16-bit device on chip select 5, block of 4 words.
        reg_write(2'd1, 32'h0000_008B, "R5 config cs5 16-bit");
        reg_write(2'd2, 32'd3 << 22, "R6 size N=3");
        reg_write(2'd0, 32'h0000_0101, "R2 clear");
        xfer(3'd5, 16'h1234, "R5 two lanes word 0");
        xfer(3'd5, 16'hA5F0, "R5 two lanes word 1");
        xfer(3'd5, 16'h0001, "R5 low lane even index");
        xfer(3'd5, 16'h8000, "R6 done after 4 words");
        xfer(3'd5, 16'hFFFF, "R10 frozen 16-bit");

        // Erased 512-byte block, 16-bit device.
        reg_write(2'd2, 32'd255 << 22, "R6 size N=255");
        reg_write(2'd0, 32'h0000_0101, "R2 clear");
        for (int i = 0; i < 256; i++) xfer(3'd5, 16'hFFFF, "R9 erased block");
        n_chk++;
        if (ecc_result !== 32'd0 || ecc_done !== 1'b1) begin
            n_fail++;
            $display("FAIL R9: result=%h done=%0b expected result=00000000 done=1",
                     ecc_result, ecc_done);
        end

        // Patterned 512-byte block, 8-bit device: exercises every row pair.
        reg_write(2'd1, 32'h0000_000B, "R5 config cs5 8-bit");
        reg_write(2'd0, 32'h0000_0101, "R2 clear");
        for (int i = 0; i < 512; i++)
            xfer(3'd5, 16'((i * 37 + 11) & 255), "R8 rows over 512 bytes");
        xfer(3'd5, 16'h0001, "R10 frozen after full block");

        @(negedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule